// File: doc/BRIEF.md
# SHA-512 Message Schedule Partial-Sum Stage

This block forms the first half of the SHA-512 message expansion for four words at a time. It takes a 256-bit vector holding four consecutive 64-bit message words and a 128-bit vector whose low word holds the word that follows them. For each of the four lanes it adds that lane's word to the small sigma-zero of the next word. A later stage adds the sigma-one term and finishes the expansion.

All four lanes are computed in parallel in one cycle, and the result is held in a single output register. Both sides use valid/ready handshakes. A transfer happens on any clock edge where valid and ready are both high. The input side is ready whenever the output register is empty, or when its current result is being taken in that same cycle. While the result is valid and the consumer holds `res_ready` low, the result does not change and no new input is accepted. There is no buffering beyond the one register. With `res_ready` held high, one result can leave every cycle.

Top module: `sha512_sched_p1`

## Requirements
- R1: Output lane i (bits 64*i+63 : 64*i, lane 0 lowest) equals input word i plus sigma0(word i+1), modulo 2^64, for i = 0..3. Words 0..3 come from bits 63:0 through 255:192 of `words_in`.
- R2: sigma0(x) = ROTR(x,1) XOR ROTR(x,8) XOR (x >> 7). ROTR is a right rotate by n mod 64, and >> is a logical shift that fills with zeros.
- R3: Word 4, the sigma input of lane 3, is bits 63:0 of `next_in`. Bits 127:64 of `next_in` have no effect on the result.
- R4: An input accepted on a clock edge (`in_valid` and `in_ready` both high) appears on `res_data` with `res_valid` high after that same edge, so the result is visible in the next cycle.
- R5: A synchronous, active-high `rst` clears `res_valid` and `res_data` to zero at the next clock edge, whatever the handshake state.
- R6: `in_ready` is high exactly when `res_valid` is low or `res_ready` is high. While `res_valid` is high and `res_ready` is low, `res_valid` and `res_data` stay unchanged at the next edge.
- R7: When the held result is taken and a new input is accepted on the same edge, the new result is valid in the next cycle with no empty cycle in between.
- R8: When the held result is taken and no input is accepted on that edge, `res_valid` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operands are valid |
| in_ready | output | 1 | Block can accept operands this cycle |
| words_in | input | 256 | Message words 0..3, word 0 in bits 63:0 |
| next_in | input | 128 | Word 4 in bits 63:0; bits 127:64 unused |
| res_valid | output | 1 | Result register holds a valid result |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_data | output | 256 | Four partial sums, lane 0 in bits 63:0 |

## Verification
Two events can fall on the same edge: the consumer draining the held result, and a new operand set being loaded into the same register. The bench provokes this by driving `in_valid` and `res_ready` randomly and independently on every cycle. It also drives long runs with both high and bursts with `res_ready` low, so that drain-and-load edges occur next to stall edges. A cycle-level model in the bench predicts the valid flag and the data after each edge. A collision is judged correct when the result that follows is the new sum, arrives in the very next cycle, and no result is lost or repeated.

// File: rtl/sha512_sched_p1_pkg.sv
package sha512_sched_p1_pkg;
  localparam int unsigned QW        = 64;
  localparam int unsigned ROT_A     = 1;
  localparam int unsigned ROT_B     = 8;
  localparam int unsigned SHIFT_C   = 7;

  typedef logic [QW-1:0] qword_t;

  function automatic qword_t rotr(input qword_t x, input int unsigned n);
    int unsigned k;
    k = n % QW;
    if (k == 0) return x;
    return (x >> k) | (x << (QW - k));
  endfunction

  function automatic qword_t small_sigma0(input qword_t x);
    return rotr(x, ROT_A) ^ rotr(x, ROT_B) ^ (x >> SHIFT_C);
  endfunction
endpackage

// File: rtl/sha512_sched_p1_lane.sv
module sha512_sched_p1_lane
  import sha512_sched_p1_pkg::*;
(
  input  logic [QW-1:0] own_word,
  input  logic [QW-1:0] next_word,
  output logic [QW-1:0] partial
);
  qword_t sig;

  always_comb begin
    sig     = small_sigma0(next_word);
    partial = own_word + sig;
  end
endmodule

// File: rtl/sha512_sched_p1_stage.sv
module sha512_sched_p1_stage #(
  parameter int unsigned DATA_W = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              take;

  always_comb begin
    up_ready = !full_q || dn_ready;
    take     = up_valid && up_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (up_ready) full_q <= up_valid;
      if (take)     data_q <= up_data;
    end
  end

  assign dn_valid = full_q;
  assign dn_data  = data_q;
endmodule

// File: rtl/sha512_sched_p1.sv
module sha512_sched_p1
  import sha512_sched_p1_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned VEC_W  = LANES * QW,
  localparam int unsigned NEXT_W = 2 * QW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VEC_W-1:0]  words_in,
  input  logic [NEXT_W-1:0] next_in,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [VEC_W-1:0]  res_data
);
  logic [QW-1:0]    w [LANES+1];
  logic [VEC_W-1:0] sums;

  // Only the low word of next_in feeds the last lane.
  logic [QW-1:0] spare_hi;
  assign spare_hi = next_in[NEXT_W-1:QW];

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_word
      assign w[i] = words_in[i*QW +: QW];
    end
  endgenerate
  assign w[LANES] = next_in[QW-1:0];

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      sha512_sched_p1_lane u_lane (
        .own_word  (w[i]),
        .next_word (w[i+1]),
        .partial   (sums[i*QW +: QW])
      );
    end
  endgenerate

  sha512_sched_p1_stage #(.DATA_W(VEC_W)) u_stage (
    .clk      (clk),
    .rst      (rst),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (sums),
    .dn_valid (res_valid),
    .dn_ready (res_ready),
    .dn_data  (res_data)
  );

  logic unused_ok;
  assign unused_ok = ^spare_hi;
endmodule

// File: rtl/sha512_sched_p1_chk.sv
module sha512_sched_p1_chk (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [255:0] words_in,
  input logic [127:0] next_in,
  input logic         res_valid,
  input logic         res_ready,
  input logic [255:0] res_data
);
  function automatic logic [63:0] s0(input logic [63:0] x);
    return {x[0], x[63:1]} ^ {x[7:0], x[63:8]} ^ {7'd0, x[63:7]};
  endfunction

  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  // R5: reset clears outputs
  always @(negedge clk)
    if (rst_seen) a_r5_reset_clear: assert (!res_valid && res_data == '0);

  // R4: accepted input becomes a valid result
  a_r4_accept: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> res_valid);

  // R6: stalled result holds
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_ready |=> res_valid && $stable(res_data));

  // R8: drained without refill goes empty
  a_r8_drain: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_ready && !in_valid |=> !res_valid);

  // R1: lane 0 sum
  a_r1_lane0: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=>
      res_data[63:0] == $past(words_in[63:0] + s0(words_in[127:64])));

  // R3: lane 3 uses low word of next_in
  a_r3_lane3: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=>
      res_data[255:192] == $past(words_in[255:192] + s0(next_in[63:0])));
endmodule

bind sha512_sched_p1 sha512_sched_p1_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .words_in(words_in), .next_in(next_in), .res_valid(res_valid),
  .res_ready(res_ready), .res_data(res_data)
);

// File: tb/sha512_sched_p1_tb.sv
module sha512_sched_p1_tb;
  localparam int PERIOD = 10;

  logic         clk = 0;
  logic         rst = 1;
  logic         in_valid = 0;
  logic         in_ready;
  logic [255:0] words_in = '0;
  logic [127:0] next_in = '0;
  logic         res_valid;
  logic         res_ready = 0;
  logic [255:0] res_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  sha512_sched_p1 u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .words_in(words_in), .next_in(next_in), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data)
  );

  function automatic logic [63:0] ror(input logic [63:0] x, input int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  function automatic logic [63:0] sg0(input logic [63:0] x);
    return ror(x, 1) ^ ror(x, 8) ^ (x >> 7);
  endfunction

  function automatic logic [255:0] expect_sum(input logic [255:0] a, input logic [127:0] b);
    logic [63:0] wd [5];
    logic [255:0] r;
    for (int i = 0; i < 4; i++) wd[i] = a[64*i +: 64];
    wd[4] = b[63:0];
    for (int i = 0; i < 4; i++) r[64*i +: 64] = wd[i] + sg0(wd[i+1]);
    return r;
  endfunction

  // cycle model of the handshake
  logic         m_valid = 0;
  logic [255:0] m_data  = '0;
  logic         m_held  = 0;
  logic         m_pair  = 0;
  always @(posedge clk) begin
    m_held = m_valid && !res_ready && !rst;
    m_pair = m_valid && res_ready && in_valid && !rst;
    if (rst) begin
      m_valid = 0; m_data = '0;
    end else if (!m_valid || res_ready) begin
      m_valid = in_valid;
      if (in_valid) m_data = expect_sum(words_in, next_in);
    end
  end

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(m_held ? "R6 valid hold" : (m_pair ? "R7 valid" : "R4/R8 valid"),
        {255'd0, res_valid}, {255'd0, m_valid});
    chk("R6 ready", {255'd0, in_ready}, {255'd0, !m_valid || res_ready});
    if (m_valid)
      chk(m_held ? "R6 data hold" : (m_pair ? "R7 data" : "R1 R2 R3 data"),
          res_data, m_data);
  endtask

  task automatic step(input logic v, input logic [255:0] a, input logic [127:0] b, input logic rr);
    in_valid = v; words_in = a; next_in = b; res_ready = rr;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  function automatic logic [255:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [255:0] a, r1v;
    logic [127:0] b;
    void'($urandom(32'h5A5A_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk("R5 reset valid", {255'd0, res_valid}, 256'd0);
    chk("R5 reset data", res_data, 256'd0);

    // R2 directed corners
    step(1, '0, '0, 1);
    step(1, {4{64'hFFFF_FFFF_FFFF_FFFF}}, {2{64'hFFFF_FFFF_FFFF_FFFF}}, 1);
    step(1, {4{64'h8000_0000_0000_0000}}, {64'h0, 64'h8000_0000_0000_0001}, 1);
    step(1, {64'd1, 64'd2, 64'd3, 64'hFFFF_FFFF_FFFF_FFFF}, {64'h0, 64'h0123_4567_89AB_CDEF}, 1);
    // R2 known value: lane 3 = 0 + sg0(1) = rotr1 | rotr8 = 0x8100...0
    step(1, '0, {64'h0, 64'd1}, 1);
    chk("R2 known sigma", {192'd0, res_data[255:192]}, {192'd0, 64'h8100_0000_0000_0000});

    // R3: upper half of next_in ignored
    a = rnd256(); b = {$urandom, $urandom, $urandom, $urandom};
    step(1, a, b, 1);
    r1v = res_data;
    step(1, a, {~b[127:64], b[63:0]}, 1);
    chk("R3 upper ignored", res_data, r1v);

    // R8 drain, R6 stall
    step(0, '0, '0, 1);
    step(1, rnd256(), '1, 0);
    step(1, rnd256(), '0, 0);
    step(1, rnd256(), '0, 1);

    // R5 reset with pending result
    step(1, rnd256(), '1, 0);
    rst = 1;
    step(0, '0, '0, 0);
    rst = 0;
    chk("R5 mid reset data", res_data, 256'd0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic rr;
      rr = (n % 500 < 100) ? 1'b1 : ($urandom % 3 != 0);
      step(($urandom % 4) != 0, rnd256(), {$urandom, $urandom, $urandom, $urandom}, rr);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule